// File: doc/BRIEF.md
# Arithmetic Unit with Status Flags

This block performs byte-wide or word-wide integer arithmetic and bitwise logic on two 16-bit operands. It keeps a 16-bit status word whose bits sit at fixed positions. Operations enter through a valid/ready handshake. Each accepted operation produces one registered result, which waits at a valid/ready output until the consumer takes it. The arithmetic status bits are written back in the same clock edge that registers the result.

Three control bits in the status word change only on plain set and clear command pins: a debug-trap enable, an interrupt enable and a string direction. The direction bit drives a pointer-step output. String-moving logic adds this value to its source and destination offsets.

Back-pressure works as follows. The input is ready whenever the output register is empty or is being drained in the same cycle. While the output is valid and not taken, it holds its value and no new operation is accepted.

Top module: `alu_flags_unit`

## Requirements
- R1: Opcode 0 adds and opcode 1 subtracts. Status bit 0 takes the carry out of the operand's top bit, or the borrow on subtract. In byte mode (`in_word`=0) only the low 8 bits of each operand are used, and result bits 15:8 are zero.
- R2: Opcodes 2, 3 and 4 give AND, OR and XOR. They clear status bits 0, 4 and 11.
- R3: Opcode 5 adds one and opcode 6 subtracts one. Both leave status bit 0 at its previous value.
- R4: Status bit 6 is set when the result is zero. Status bit 7 copies the result's top bit: bit 7 in byte mode, bit 15 in word mode.
- R5: Status bit 2 is set when result bits 7:0 hold an even number of ones, in both modes.
- R6: For arithmetic opcodes (0, 1, 5, 6), status bit 4 is set on a carry out of, or a borrow into, bit 3.
- R7: Status bit 11 is set on two's-complement overflow of an arithmetic opcode at the selected width.
- R8: Status bits 8, 9 and 10 are trap, interrupt enable and direction. They map to `ctl_set`/`ctl_clr` bits 0, 1 and 2 and change only on those pins, one edge after the command. Set wins over clear, and no opcode ever changes them.
- R9: `ptr_step` is +1 (byte) or +2 (word, `str_word`=1) when status bit 10 is 0. It is -1 or -2, in two's complement, when status bit 10 is 1.
- R10: Status bits 1, 3, 5 and 12 to 15 always read zero.
- R11: `in_ready` is high when `out_valid` is low or `out_ready` is high. An operation accepted at one edge shows its result, with `out_valid` high and its status, after that edge. A result that is not taken holds stable.
- R12: Opcode 7 passes the selected-width `in_b` to the result and leaves every arithmetic status bit unchanged.
- R13: After reset the status word is zero and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken |
| in_op | input | 3 | Opcode 0..7 |
| in_word | input | 1 | 1 = 16-bit operation, 0 = 8-bit |
| in_a | input | 16 | First operand |
| in_b | input | 16 | Second operand |
| ctl_set | input | 3 | Set trap / interrupt / direction |
| ctl_clr | input | 3 | Clear trap / interrupt / direction |
| str_word | input | 1 | Step size select for `ptr_step` |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 16 | Registered result |
| status | output | 16 | Status word |
| ptr_step | output | 16 | Signed string pointer increment |

## Verification
The result, `out_valid` and the arithmetic status bits are each one register away from the accepting edge. The bench drives on a falling edge and compares on the next falling edge after the accepting rising edge. Control commands also land one edge later and are read at the following falling edge. `ptr_step` is combinational from the status register, so it is read in that same window. For the stall case, the held result is compared at several falling edges in a row, and the queued operation is checked only in the cycle after `out_ready` rises.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int DW  = 16;
  localparam int BW  = 8;
  localparam int NIB = 4;
  localparam int NCTL = 3;

  localparam int FLG_C = 0;
  localparam int FLG_P = 2;
  localparam int FLG_A = 4;
  localparam int FLG_Z = 6;
  localparam int FLG_S = 7;
  localparam int FLG_T = 8;
  localparam int FLG_I = 9;
  localparam int FLG_D = 10;
  localparam int FLG_O = 11;

  localparam logic [DW-1:0] UNUSED_MASK = 16'hF02A;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4,
    OP_INC = 3'd5,
    OP_DEC = 3'd6,
    OP_MOV = 3'd7
  } op_e;
endpackage

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
(
  input  op_e            op,
  input  logic           word,
  input  logic [DW-1:0]  a,
  input  logic [DW-1:0]  b,
  input  logic           c_in,
  output logic [DW-1:0]  res,
  output logic           c_out,
  output logic           aux_out,
  output logic           ovf_out,
  output logic           upd
);
  logic [DW-1:0] mask, am, bm, opnd;
  logic [DW:0]   sum, diff, raw;
  logic          is_sub, is_arith, s_a, s_o, s_r, cy;

  always_comb begin
    mask = word ? {DW{1'b1}} : {{(DW-BW){1'b0}}, {BW{1'b1}}};
    am   = a & mask;
    bm   = b & mask;
    opnd = (op == OP_INC || op == OP_DEC) ? {{(DW-1){1'b0}}, 1'b1} : bm;
    sum  = {1'b0, am} + {1'b0, opnd};
    diff = {1'b0, am} - {1'b0, opnd};
    is_sub   = (op == OP_SUB) || (op == OP_DEC);
    is_arith = (op == OP_ADD) || (op == OP_SUB) || (op == OP_INC) || (op == OP_DEC);
    raw  = is_sub ? diff : sum;
    cy   = word ? raw[DW] : raw[BW];

    case (op)
      OP_AND:  res = am & bm;
      OP_OR:   res = am | bm;
      OP_XOR:  res = am ^ bm;
      OP_MOV:  res = bm;
      default: res = raw[DW-1:0] & mask;
    endcase

    s_a = word ? am[DW-1]   : am[BW-1];
    s_o = word ? opnd[DW-1] : opnd[BW-1];
    s_r = word ? res[DW-1]  : res[BW-1];

    upd     = (op != OP_MOV);
    aux_out = is_arith & (am[NIB] ^ opnd[NIB] ^ res[NIB]);
    if (!is_arith)
      ovf_out = 1'b0;
    else if (is_sub)
      ovf_out = (s_a != s_o) && (s_r != s_a);
    else
      ovf_out = (s_a == s_o) && (s_r != s_a);

    if (op == OP_ADD || op == OP_SUB) c_out = cy;
    else if (op == OP_INC || op == OP_DEC) c_out = c_in;
    else c_out = 1'b0;
  end
endmodule

// File: rtl/alu_flag_merge.sv
module alu_flag_merge
  import alu_pkg::*;
(
  input  logic [DW-1:0]   res,
  input  logic            word,
  input  logic            c_new,
  input  logic            aux_new,
  input  logic            ovf_new,
  input  logic            upd,
  input  logic            take,
  input  logic [DW-1:0]   st_q,
  input  logic [NCTL-1:0] set_cmd,
  input  logic [NCTL-1:0] clr_cmd,
  output logic [DW-1:0]   st_d
);
  logic [NCTL-1:0] ctl_q;

  always_comb begin
    st_d  = '0;
    ctl_q = st_q[FLG_T +: NCTL];
    st_d[FLG_T +: NCTL] = (ctl_q & ~clr_cmd) | set_cmd;
    if (take && upd) begin
      st_d[FLG_C] = c_new;
      st_d[FLG_P] = ~^res[BW-1:0];
      st_d[FLG_A] = aux_new;
      st_d[FLG_Z] = (res == '0);
      st_d[FLG_S] = word ? res[DW-1] : res[BW-1];
      st_d[FLG_O] = ovf_new;
    end else begin
      st_d[FLG_C] = st_q[FLG_C];
      st_d[FLG_P] = st_q[FLG_P];
      st_d[FLG_A] = st_q[FLG_A];
      st_d[FLG_Z] = st_q[FLG_Z];
      st_d[FLG_S] = st_q[FLG_S];
      st_d[FLG_O] = st_q[FLG_O];
    end
  end
endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
  import alu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [2:0]      in_op,
  input  logic            in_word,
  input  logic [DW-1:0]   in_a,
  input  logic [DW-1:0]   in_b,
  input  logic [NCTL-1:0] ctl_set,
  input  logic [NCTL-1:0] ctl_clr,
  input  logic            str_word,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [DW-1:0]   out_result,
  output logic [DW-1:0]   status,
  output logic [DW-1:0]   ptr_step
);
  logic [DW-1:0] res_c, st_d, step_mag;
  logic c_n, a_n, o_n, upd, take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  alu_datapath u_dp (
    .op(op_e'(in_op)), .word(in_word), .a(in_a), .b(in_b),
    .c_in(status[FLG_C]), .res(res_c), .c_out(c_n),
    .aux_out(a_n), .ovf_out(o_n), .upd(upd)
  );

  alu_flag_merge u_fm (
    .res(res_c), .word(in_word), .c_new(c_n), .aux_new(a_n),
    .ovf_new(o_n), .upd(upd), .take(take), .st_q(status),
    .set_cmd(ctl_set), .clr_cmd(ctl_clr), .st_d(st_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      status     <= '0;
    end else begin
      status <= st_d;
      if (take) begin
        out_valid  <= 1'b1;
        out_result <= res_c;
      end else if (out_ready) begin
        out_valid  <= 1'b0;
      end
    end
  end

  assign step_mag = str_word ? DW'(2) : DW'(1);
  assign ptr_step = status[FLG_D] ? (~step_mag + DW'(1)) : step_mag;
endmodule

// File: rtl/alu_flags_unit_chk.sv
module alu_flags_unit_chk
  import alu_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [NCTL-1:0] ctl_set,
  input logic [NCTL-1:0] ctl_clr,
  input logic            out_valid,
  input logic            out_ready,
  input logic [DW-1:0]   out_result,
  input logic [DW-1:0]   status,
  input logic [DW-1:0]   ptr_step
);
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_set == '0 && ctl_clr == '0) |=> status[FLG_T +: NCTL] == $past(status[FLG_T +: NCTL])); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_set[2] |=> status[FLG_D]); // R8
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (status & UNUSED_MASK) == '0); // R10
  AST_STEP_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_step[DW-1] == status[FLG_D]); // R9
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result))); // R11
endmodule

bind alu_flags_unit alu_flags_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_set(ctl_set), .ctl_clr(ctl_clr),
  .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
  .status(status), .ptr_step(ptr_step)
);

// File: tb/alu_flags_unit_tb.sv
module alu_flags_unit_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_word = 1'b0, str_word = 1'b0, out_ready = 1'b1;
  logic [2:0] in_op = 3'd0, ctl_set = 3'd0, ctl_clr = 3'd0;
  logic [15:0] in_a = 16'h0, in_b = 16'h0;
  logic in_ready, out_valid;
  logic [15:0] out_result, status, ptr_step;
  int checks = 0, fails = 0;
  logic [15:0] exp_st = 16'h0;

  always #4 clk = ~clk;

  alu_flags_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_word(in_word), .in_a(in_a), .in_b(in_b),
    .ctl_set(ctl_set), .ctl_clr(ctl_clr), .str_word(str_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .status(status), .ptr_step(ptr_step)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected result and arithmetic status bits, written from the requirements
  function automatic logic [15:0] model(input logic [2:0] op, input logic w,
                                         input logic [15:0] a, input logic [15:0] b);
    logic [15:0] mask, am, bm, r, o;
    logic [16:0] full;
    logic c, ax, ov, sa, so, sr;
    int top;
    mask = w ? 16'hFFFF : 16'h00FF;
    top = w ? 15 : 7;
    am = a & mask; bm = b & mask;
    o = (op == 3'd5 || op == 3'd6) ? 16'h0001 : bm;
    c = 1'b0; ax = 1'b0; ov = 1'b0;
    sa = am[top]; so = o[top];
    case (op)
      3'd0, 3'd5: begin
        full = {1'b0, am} + {1'b0, o};
        r = full[15:0] & mask;
        c = (op == 3'd5) ? exp_st[0] : (w ? full[16] : full[8]);
        sr = r[top];
        ov = (sa == so) && (sr != sa);
        ax = (am[3:0] + o[3:0]) > 5'd15;
      end
      3'd1, 3'd6: begin
        r = (am - o) & mask;
        c = (op == 3'd6) ? exp_st[0] : (am < o);
        sr = r[top];
        ov = (sa != so) && (sr != sa);
        ax = am[3:0] < o[3:0];
      end
      3'd2: r = am & bm;
      3'd3: r = am | bm;
      3'd4: r = am ^ bm;
      default: r = bm;
    endcase
    if (op != 3'd7) begin
      exp_st[0] = c; exp_st[2] = ~^r[7:0]; exp_st[4] = ax;
      exp_st[6] = (r == 16'h0); exp_st[7] = r[top]; exp_st[11] = ov;
    end
    return r;
  endfunction

  task automatic run_op(input string req, input logic [2:0] op, input logic w,
                        input logic [15:0] a, input logic [15:0] b);
    logic [15:0] r;
    @(negedge clk);
    in_op = op; in_word = w; in_a = a; in_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    r = model(op, w, a, b);
    chk({req, " valid"}, {15'h0, out_valid}, 16'h1);
    chk({req, " result"}, out_result, r);
    chk({req, " status"}, status, exp_st);
  endtask

  task automatic t_reset;
    chk("R13 status", status, 16'h0);
    chk("R13 out_valid", {15'h0, out_valid}, 16'h0);
    chk("R11 in_ready idle", {15'h0, in_ready}, 16'h1);
    chk("R9 step fwd byte", ptr_step, 16'h0001);
  endtask

  task automatic t_add_sub;
    run_op("R1 R7 word add overflow", 3'd0, 1'b1, 16'h7FFF, 16'h0001);
    chk("R7 ovf bit", {15'h0, status[11]}, 16'h1);
    run_op("R1 R4 byte add carry zero", 3'd0, 1'b0, 16'h12FF, 16'h3401);
    chk("R4 zero bit", {15'h0, status[6]}, 16'h1);
    run_op("R1 byte sub borrow", 3'd1, 1'b0, 16'hAA00, 16'h0001);
    chk("R1 borrow", {15'h0, status[0]}, 16'h1);
    run_op("R1 R6 word sub", 3'd1, 1'b1, 16'h1000, 16'h0001);
    chk("R6 aux borrow", {15'h0, status[4]}, 16'h1);
    run_op("R1 R5 byte add upper junk", 3'd0, 1'b0, 16'hAB12, 16'hCD03);
    chk("R5 parity odd", {15'h0, status[2]}, 16'h0);
    run_op("R7 byte sub overflow", 3'd1, 1'b0, 16'h0080, 16'h0001);
  endtask

  task automatic t_logic;
    run_op("R1 set carry", 3'd0, 1'b1, 16'hFFFF, 16'h0001);
    run_op("R2 and", 3'd2, 1'b1, 16'hF0F0, 16'h8F0F);
    run_op("R2 or", 3'd3, 1'b0, 16'h0081, 16'h0003);
    run_op("R2 xor word", 3'd4, 1'b1, 16'hA5A5, 16'hA5A5);
  endtask

  task automatic t_incdec;
    run_op("R1 set carry", 3'd0, 1'b0, 16'h00F0, 16'h0020);
    run_op("R3 inc keeps carry", 3'd5, 1'b0, 16'h000F, 16'h0);
    chk("R3 carry kept", {15'h0, status[0]}, 16'h1);
    run_op("R3 dec word ovf", 3'd6, 1'b1, 16'h8000, 16'h0);
    run_op("R3 inc byte wrap", 3'd5, 1'b0, 16'h00FF, 16'h0);
  endtask

  task automatic t_move;
    run_op("R12 prime flags", 3'd1, 1'b1, 16'h0001, 16'h0002);
    run_op("R12 move", 3'd7, 1'b0, 16'h1234, 16'hBEEF);
  endtask

  task automatic t_ctrl;
    @(negedge clk); ctl_set = 3'b100;
    @(negedge clk); ctl_set = 3'b000;
    exp_st[10] = 1'b1;
    chk("R8 dir set", status, exp_st);
    str_word = 1'b0; #1;
    chk("R9 step back byte", ptr_step, 16'hFFFF);
    str_word = 1'b1; #1;
    chk("R9 step back word", ptr_step, 16'hFFFE);
    ctl_set = 3'b011; ctl_clr = 3'b001;
    @(negedge clk); ctl_set = 3'b000; ctl_clr = 3'b000;
    exp_st[8] = 1'b1; exp_st[9] = 1'b1;
    chk("R8 set wins", status, exp_st);
    run_op("R8 op leaves controls", 3'd4, 1'b1, 16'hFFFF, 16'h0000);
    chk("R10 unused zero", status & 16'hF02A, 16'h0);
    ctl_clr = 3'b101;
    @(negedge clk); ctl_clr = 3'b000;
    exp_st[8] = 1'b0; exp_st[10] = 1'b0;
    chk("R8 clear", status, exp_st);
    chk("R9 step fwd word", ptr_step, 16'h0002);
    str_word = 1'b0;
  endtask

  task automatic t_backpressure;
    logic [15:0] ra, rb;
    @(negedge clk);
    out_ready = 1'b0;
    in_op = 3'd0; in_word = 1'b1; in_a = 16'h0100; in_b = 16'h0023; in_valid = 1'b1;
    @(negedge clk);
    ra = model(3'd0, 1'b1, 16'h0100, 16'h0023);
    chk("R11 accepted", out_result, ra);
    chk("R11 ready low", {15'h0, in_ready}, 16'h0);
    in_op = 3'd1; in_a = 16'h0005; in_b = 16'h0005;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk("R11 held", out_result, ra);
      chk("R11 status held", status, exp_st);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    rb = model(3'd1, 1'b1, 16'h0005, 16'h0005);
    chk("R11 next result", out_result, rb);
    chk("R11 next status", status, exp_st);
    @(negedge clk);
    chk("R11 drained", {15'h0, out_valid}, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_add_sub();
    t_logic();
    t_incdec();
    t_move();
    t_ctrl();
    t_backpressure();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule